// File: doc/BRIEF.md
# Single-Precision to Bfloat16 Narrowing Converter

This block narrows a 32-bit IEEE single-precision word into a 16-bit bfloat16 word. Both formats use an 8-bit exponent with the same bias, so the exponent field carries across untouched. Only the significand is shortened: the 23 stored fraction bits become 7, and the 16 bits that drop out are resolved by one of four selectable rounding rules. Infinities, NaNs and signed zeros keep their class. The narrow format has no subnormals, so any input whose exponent field is zero comes out as a zero of the same sign.

The converter is a pure datapath with an optional output register, chosen by a parameter. With the default setting the result appears one clock after the input is applied. Two flags come out with each result. One reports that information was discarded. The other reports that a finite input sat above the largest finite bfloat16 value and either became infinity or was held at that largest value.

Top module: `fp32_to_bf16_cvt`

## Requirements
- R1: Output bit 15 is the input sign (bit 31), output bits 14:7 are the input exponent (bits 30:23), and output bits 6:0 are input bits 22:16 whenever no rounding increment applies; an input whose bits 15:0 are all zero converts exactly with the inexact flag low.
- R2: The roundMode input is decoded as 2'b00 round to nearest with ties to even, 2'b01 round toward zero, 2'b10 round toward +infinity, 2'b11 round toward -infinity.
- R3: In nearest-even mode the magnitude is incremented when bit 15 is 1 and either some bit of 14:0 is 1 or bit 16 is 1; an exact tie (bit 15 set, bits 14:0 clear) leaves an even kept value unchanged.
- R4: In toward-zero mode the 16 low input bits are dropped, and the magnitude is never incremented, for either sign.
- R5: In toward-+infinity mode the magnitude is incremented only for a positive input with nonzero bits 15:0; in toward--infinity mode only for a negative input with nonzero bits 15:0.
- R6: An increment that carries out of the 7 fraction bits raises the exponent by one and clears the fraction.
- R7: A finite input with exponent 0xFE, bits 22:16 all ones and nonzero bits 15:0 raises the overflow flag; the output is infinity (magnitude 0x7F80) if the mode increments it, otherwise the largest finite value (magnitude 0x7F7F). The exact largest finite value does not raise the flag.
- R8: An input with a zero exponent field (zero or subnormal) produces a zero of the input's sign in every mode; inexact is set exactly when its fraction is nonzero.
- R9: A NaN input (exponent 0xFF, nonzero fraction) produces exponent 0xFF with output bit 6 forced to 1 and bits 5:0 copied from input bits 21:16, sign kept, and both flags low.
- R10: An infinity input produces an infinity of the same sign in every mode, with both flags low.
- R11: For a finite input with a nonzero exponent, inexact is set exactly when input bits 15:0 are nonzero.
- R12: With the output register enabled (default), reset drives all outputs to zero and each result appears on the clock edge after its input is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| fpIn | input | 32 | Single-precision input word |
| roundMode | input | 2 | Rounding rule select, encoding in R2 |
| bfOut | output | 16 | Bfloat16 result |
| inexact | output | 1 | Discarded bits were nonzero |
| overflow | output | 1 | Finite input above the largest finite output value |

## Verification
The hardest corner to reach from the ports is the top of the finite range, where one input pattern (exponent 0xFE, kept fraction all ones, nonzero tail) must split into infinity or the largest finite value depending on mode and sign, while a neighbouring exact pattern must not flag at all. The stimulus drives the largest single-precision values of both signs through all four modes, plus the exact largest bfloat16 value and a pattern just above it that rounds down under nearest-even. Tie handling is reached with hand-built tails that set only the guard bit, against both an even and an odd kept value, and a carry that crosses into the exponent is forced with a tie on an all-ones fraction.

// File: rtl/bf16cvt_pkg.sv
package bf16cvt_pkg;

  localparam int EXP_W      = 8;
  localparam int SRC_FRAC_W = 23;
  localparam int DST_FRAC_W = 7;
  localparam int SRC_W      = 1 + EXP_W + SRC_FRAC_W;
  localparam int DST_W      = 1 + EXP_W + DST_FRAC_W;
  localparam int MAG_W      = EXP_W + DST_FRAC_W;
  localparam int DROP_W     = SRC_FRAC_W - DST_FRAC_W;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_TO_ZERO   = 2'b01,
    RND_TO_POS    = 2'b10,
    RND_TO_NEG    = 2'b11
  } roundMode_e;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic selNan;    // input is a NaN
    logic selInf;    // input is an infinity
    logic selFlush;  // input exponent is zero: emit signed zero
    logic incMag;    // add one ulp to the kept magnitude
    logic atTop;     // finite input sits in the top bfloat16 binade slot
    logic lostBits;  // some discarded bit was nonzero
  } cvtStrobes_t;

endpackage

// File: rtl/bf16cvt_ctrl.sv
module bf16cvt_ctrl
  import bf16cvt_pkg::*;
(
  input  logic                  signBit,
  input  logic [EXP_W-1:0]      expField,
  input  logic [SRC_FRAC_W-1:0] fracField,
  input  logic [1:0]            modeSel,
  output cvtStrobes_t           strobes
);

  localparam logic [EXP_W-1:0] EXP_TOP_FINITE = {{(EXP_W-1){1'b1}}, 1'b0};

  logic       expAllOnes;
  logic       expAllZero;
  logic       fracNonZero;
  logic       keptLsb;
  logic       guardBit;
  logic       stickyBit;
  logic       tailNonZero;
  logic       keptAllOnes;
  logic       isNormal;
  logic       wantUp;
  roundMode_e mode;

  assign mode        = roundMode_e'(modeSel);
  assign expAllOnes  = &expField;
  assign expAllZero  = ~|expField;
  assign fracNonZero = |fracField;
  assign keptLsb     = fracField[DROP_W];
  assign guardBit    = fracField[DROP_W-1];
  assign stickyBit   = |fracField[DROP_W-2:0];
  assign tailNonZero = |fracField[DROP_W-1:0];
  assign keptAllOnes = &fracField[SRC_FRAC_W-1:DROP_W];
  assign isNormal    = !expAllOnes && !expAllZero;

  always_comb begin
    unique case (mode)
      RND_NEAR_EVEN: wantUp = guardBit && (stickyBit || keptLsb);
      RND_TO_ZERO:   wantUp = 1'b0;
      RND_TO_POS:    wantUp = tailNonZero && !signBit;
      RND_TO_NEG:    wantUp = tailNonZero && signBit;
      default:       wantUp = 1'b0;
    endcase
  end

  always_comb begin
    strobes.selNan   = expAllOnes && fracNonZero;
    strobes.selInf   = expAllOnes && !fracNonZero;
    strobes.selFlush = expAllZero;
    strobes.incMag   = isNormal && wantUp;
    strobes.atTop    = isNormal && (expField == EXP_TOP_FINITE) && keptAllOnes;
    strobes.lostBits = expAllZero ? fracNonZero : tailNonZero;
  end

endmodule

// File: rtl/bf16cvt_datapath.sv
module bf16cvt_datapath
  import bf16cvt_pkg::*;
(
  input  logic                  signBit,
  input  logic [EXP_W-1:0]      expField,
  input  logic [SRC_FRAC_W-1:0] fracField,
  input  cvtStrobes_t           strobes,
  output logic [DST_W-1:0]      result,
  output logic                  inexactFlag,
  output logic                  overflowFlag
);

  localparam logic [DST_FRAC_W-1:0] QUIET_BIT = {1'b1, {(DST_FRAC_W-1){1'b0}}};

  logic [DST_FRAC_W-1:0] keptFrac;
  logic [MAG_W-1:0]      magTrunc;
  logic [MAG_W-1:0]      magRounded;
  logic                  isSpecial;

  assign keptFrac   = fracField[SRC_FRAC_W-1:DROP_W];
  assign magTrunc   = {expField, keptFrac};
  // Carry out of the fraction walks into the exponent; from the top
  // finite slot it lands on the all-ones exponent with a clear fraction.
  assign magRounded = magTrunc + {{(MAG_W-1){1'b0}}, strobes.incMag};
  assign isSpecial  = strobes.selNan || strobes.selInf;

  always_comb begin
    if (strobes.selNan) begin
      result = {signBit, {EXP_W{1'b1}}, keptFrac | QUIET_BIT};
    end else if (strobes.selInf) begin
      result = {signBit, {EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}};
    end else if (strobes.selFlush) begin
      result = {signBit, {MAG_W{1'b0}}};
    end else begin
      result = {signBit, magRounded};
    end
  end

  assign inexactFlag  = !isSpecial && strobes.lostBits;
  assign overflowFlag = strobes.atTop && strobes.lostBits;

endmodule

// File: rtl/fp32_to_bf16_cvt.sv
module fp32_to_bf16_cvt
  import bf16cvt_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] fpIn,
  input  logic [1:0]  roundMode,
  output logic [15:0] bfOut,
  output logic        inexact,
  output logic        overflow
);

  logic                  signBit;
  logic [EXP_W-1:0]      expField;
  logic [SRC_FRAC_W-1:0] fracField;
  cvtStrobes_t           strobes;
  logic [DST_W-1:0]      resultComb;
  logic                  inexactComb;
  logic                  overflowComb;

  assign signBit   = fpIn[SRC_W-1];
  assign expField  = fpIn[SRC_W-2 -: EXP_W];
  assign fracField = fpIn[SRC_FRAC_W-1:0];

  bf16cvt_ctrl u_ctrl (
    .signBit   (signBit),
    .expField  (expField),
    .fracField (fracField),
    .modeSel   (roundMode),
    .strobes   (strobes)
  );

  bf16cvt_datapath u_dp (
    .signBit      (signBit),
    .expField     (expField),
    .fracField    (fracField),
    .strobes      (strobes),
    .result       (resultComb),
    .inexactFlag  (inexactComb),
    .overflowFlag (overflowComb)
  );

  generate
    if (OUT_REG) begin : g_outReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bfOut    <= '0;
          inexact  <= 1'b0;
          overflow <= 1'b0;
        end else begin
          bfOut    <= resultComb;
          inexact  <= inexactComb;
          overflow <= overflowComb;
        end
      end
    end else begin : g_outComb
      assign bfOut    = resultComb;
      assign inexact  = inexactComb;
      assign overflow = overflowComb;
    end
  endgenerate

endmodule

// File: rtl/bf16cvt_checker.sv
module bf16cvt_checker
  import bf16cvt_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] fpIn,
  input logic [1:0]  roundMode,
  input logic [15:0] bfOut,
  input logic        inexact,
  input logic        overflow
);

  localparam logic [MAG_W-1:0] INF_MAG = {{EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}};
  localparam logic [MAG_W-1:0] MAX_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {DST_FRAC_W{1'b1}}};

  logic [31:0] inSeen;
  logic [1:0]  modeSeen;
  logic        seenValid;

  generate
    if (OUT_REG) begin : g_lag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          inSeen    <= '0;
          modeSeen  <= '0;
          seenValid <= 1'b0;
        end else begin
          inSeen    <= fpIn;
          modeSeen  <= roundMode;
          seenValid <= 1'b1;
        end
      end
    end else begin : g_noLag
      assign inSeen    = fpIn;
      assign modeSeen  = roundMode;
      assign seenValid = 1'b1;
    end
  endgenerate

  logic [EXP_W-1:0] seenExp;
  logic             seenFracNz;
  logic             seenTailNz;
  assign seenExp    = inSeen[30:23];
  assign seenFracNz = |inSeen[22:0];
  assign seenTailNz = |inSeen[15:0];

  assert_sign_kept_R1: assert property (@(posedge clk) disable iff (!rstN)
    seenValid |-> bfOut[15] == inSeen[31]);

  assert_truncate_R4: assert property (@(posedge clk) disable iff (!rstN)
    seenValid && modeSeen == 2'b01 && seenExp != '0 && !(&seenExp)
    |-> bfOut == inSeen[31:16]);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    seenValid && overflow |-> (bfOut[14:0] == INF_MAG || bfOut[14:0] == MAX_MAG));

  assert_flush_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    seenValid && seenExp == '0 |-> bfOut[14:0] == '0 && inexact == seenFracNz && !overflow);

  assert_nan_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    seenValid && (&seenExp) && seenFracNz
    |-> (&bfOut[14:7]) && bfOut[6] && !inexact && !overflow);

  assert_inf_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    seenValid && (&seenExp) && !seenFracNz
    |-> bfOut[14:0] == INF_MAG && !inexact && !overflow);

  assert_inexact_R11: assert property (@(posedge clk) disable iff (!rstN)
    seenValid && seenExp != '0 && !(&seenExp) |-> inexact == seenTailNz);

endmodule

bind fp32_to_bf16_cvt bf16cvt_checker #(.OUT_REG(OUT_REG)) u_bf16cvtChecker (
  .clk       (clk),
  .rstN      (rstN),
  .fpIn      (fpIn),
  .roundMode (roundMode),
  .bfOut     (bfOut),
  .inexact   (inexact),
  .overflow  (overflow)
);

// File: tb/test_fp32_to_bf16_cvt.sv
module test_fp32_to_bf16_cvt;

  logic        clk;
  logic        rstN;
  logic [31:0] fpIn;
  logic [1:0]  roundMode;
  logic [15:0] bfOut;
  logic        inexact;
  logic        overflow;

  int nVec;
  int nBad;
  bit finished;

  localparam logic [1:0] M_NE  = 2'b00;
  localparam logic [1:0] M_RZ  = 2'b01;
  localparam logic [1:0] M_POS = 2'b10;
  localparam logic [1:0] M_NEG = 2'b11;

  fp32_to_bf16_cvt i_fp32_to_bf16_cvt (
    .clk       (clk),
    .rstN      (rstN),
    .fpIn      (fpIn),
    .roundMode (roundMode),
    .bfOut     (bfOut),
    .inexact   (inexact),
    .overflow  (overflow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic compare(input string tag, input logic [15:0] eo,
                         input logic ei, input logic eov);
    nVec++;
    if (bfOut !== eo || inexact !== ei || overflow !== eov) begin
      nBad++;
      $display("FAIL %s: got out=%h inx=%b ovf=%b, expected out=%h inx=%b ovf=%b",
               tag, bfOut, inexact, overflow, eo, ei, eov);
    end
  endtask

  task automatic runVec(input string tag, input logic [31:0] a, input logic [1:0] m,
                        input logic [15:0] eo, input logic ei, input logic eov);
    @(negedge clk);
    fpIn = a;
    roundMode = m;
    @(posedge clk);
    @(negedge clk);
    compare($sformatf("%s in=%h mode=%0d", tag, a, m), eo, ei, eov);
  endtask

  task automatic testReset;
    rstN = 1'b0;
    fpIn = 32'h3F80_0000;
    roundMode = M_NE;
    repeat (3) @(negedge clk);
    compare("R12 reset holds zero", 16'h0000, 1'b0, 1'b0);
    rstN = 1'b1;
  endtask

  task automatic testExact;
    runVec("R1 exact one", 32'h3F80_0000, M_NE, 16'h3F80, 1'b0, 1'b0);
    runVec("R1 exact neg", 32'hC0A5_0000, M_POS, 16'hC0A5, 1'b0, 1'b0);
    runVec("R2 mode 00 nearest", 32'h3F80_C000, M_NE, 16'h3F81, 1'b1, 1'b0);
  endtask

  task automatic testNearest;
    runVec("R3 tie even stays", 32'h3F80_8000, M_NE, 16'h3F80, 1'b1, 1'b0);
    runVec("R3 tie odd goes up", 32'h3F81_8000, M_NE, 16'h3F82, 1'b1, 1'b0);
    runVec("R3 below half", 32'h3F80_7FFF, M_NE, 16'h3F80, 1'b1, 1'b0);
    runVec("R3 above half neg", 32'hBF80_C000, M_NE, 16'hBF81, 1'b1, 1'b0);
  endtask

  task automatic testDirected;
    runVec("R4 toward zero pos", 32'h3F81_FFFF, M_RZ, 16'h3F81, 1'b1, 1'b0);
    runVec("R4 toward zero neg", 32'hBF81_FFFF, M_RZ, 16'hBF81, 1'b1, 1'b0);
    runVec("R5 to pos on pos", 32'h3F80_0001, M_POS, 16'h3F81, 1'b1, 1'b0);
    runVec("R5 to pos on neg", 32'hBF80_0001, M_POS, 16'hBF80, 1'b1, 1'b0);
    runVec("R5 to neg on neg", 32'hBF80_0001, M_NEG, 16'hBF81, 1'b1, 1'b0);
    runVec("R5 to neg on pos", 32'h3F80_0001, M_NEG, 16'h3F80, 1'b1, 1'b0);
  endtask

  task automatic testCarry;
    runVec("R6 carry into exponent", 32'h3FFF_8000, M_NE, 16'h4000, 1'b1, 1'b0);
    runVec("R6 carry to pos", 32'h407F_0001, M_POS, 16'h4080, 1'b1, 1'b0);
  endtask

  task automatic testTop;
    runVec("R7 max fp32 nearest", 32'h7F7F_FFFF, M_NE, 16'h7F80, 1'b1, 1'b1);
    runVec("R7 max fp32 toward zero", 32'h7F7F_FFFF, M_RZ, 16'h7F7F, 1'b1, 1'b1);
    runVec("R7 max fp32 to neg", 32'h7F7F_FFFF, M_NEG, 16'h7F7F, 1'b1, 1'b1);
    runVec("R7 max fp32 to pos", 32'h7F7F_FFFF, M_POS, 16'h7F80, 1'b1, 1'b1);
    runVec("R7 neg max to pos", 32'hFF7F_FFFF, M_POS, 16'hFF7F, 1'b1, 1'b1);
    runVec("R7 neg max to neg", 32'hFF7F_FFFF, M_NEG, 16'hFF80, 1'b1, 1'b1);
    runVec("R7 just above max nearest", 32'h7F7F_0001, M_NE, 16'h7F7F, 1'b1, 1'b1);
    runVec("R7 exact max no flag", 32'h7F7F_0000, M_POS, 16'h7F7F, 1'b0, 1'b0);
  endtask

  task automatic testFlush;
    runVec("R8 subnormal pos", 32'h0040_0000, M_NE, 16'h0000, 1'b1, 1'b0);
    runVec("R8 subnormal to pos", 32'h007F_FFFF, M_POS, 16'h0000, 1'b1, 1'b0);
    runVec("R8 tiny neg to neg", 32'h8000_0001, M_NEG, 16'h8000, 1'b1, 1'b0);
    runVec("R8 neg zero", 32'h8000_0000, M_NE, 16'h8000, 1'b0, 1'b0);
  endtask

  task automatic testSpecials;
    runVec("R9 quiet nan", 32'h7FC0_0000, M_NE, 16'h7FC0, 1'b0, 1'b0);
    runVec("R9 low payload nan", 32'h7F80_0001, M_RZ, 16'h7FC0, 1'b0, 1'b0);
    runVec("R9 neg nan payload", 32'hFFA5_0000, M_POS, 16'hFFE5, 1'b0, 1'b0);
    runVec("R10 pos inf", 32'h7F80_0000, M_NEG, 16'h7F80, 1'b0, 1'b0);
    runVec("R10 neg inf", 32'hFF80_0000, M_POS, 16'hFF80, 1'b0, 1'b0);
  endtask

  task automatic testInexact;
    runVec("R11 low bit only", 32'h4120_0001, M_RZ, 16'h4120, 1'b1, 1'b0);
    runVec("R11 clean tail", 32'h4120_0000, M_NE, 16'h4120, 1'b0, 1'b0);
  endtask

  task automatic testLatency;
    runVec("R12 setup", 32'h4000_0000, M_NE, 16'h4000, 1'b0, 1'b0);
    @(negedge clk);
    fpIn = 32'hC040_0000;
    roundMode = M_NE;
    #2;
    compare("R12 output waits for edge", 16'h4000, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    compare("R12 output after edge", 16'hC040, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    nVec = 0;
    nBad = 0;
    finished = 1'b0;
    testReset();
    testExact();
    testNearest();
    testDirected();
    testCarry();
    testTop();
    testFlush();
    testSpecials();
    testInexact();
    testLatency();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule